// File: doc/BRIEF.md
# Registered Two-Way Bus Transfer Unit

This block joins two bidirectional data buses, called A and B, and passes data across them in either direction. For each direction it can forward the value now present on the source bus, or a value captured earlier into a storage register that belongs to that direction. Each direction has its own capture clock, its own drive enable and its own live/stored select. The A-to-B drive enable is active high. The B-to-A drive enable is active low.

Each bus appears at the ports as three separate signals: an input, an output and an output enable. This keeps the block synthesizable. A wrapper around the block, or the bench, resolves these signals into a shared wire. Suppose both directions are enabled and both pick the live source. Each bus is then driven with the value of the other bus, which in turn was driven from the first one. The pair therefore holds its last value after every outside driver lets go. The live/stored output multiplexer also carries a consensus term, so an output bit whose two sources agree does not change while the select switches.

Top module: `dualbus_xfer`

## Requirements
- R1: On a rising edge of `ckAb`, the A-side store register takes the value on `aIn`.
- R2: On a rising edge of `ckBa`, the B-side store register takes the value on `bIn`.
- R3: A capture happens whatever the selects and enables are doing. A capture edge on one direction's clock leaves the other direction's register unchanged.
- R4: When `rstN` is low at a rising edge of a direction clock, that direction's register is cleared to 0 (synchronous reset).
- R5: When `selAb` is 0, `bOut` equals `aIn`. When `selBa` is 0, `aOut` equals `bIn`.
- R6: When `selAb` is 1, `bOut` equals the A-side register. When `selBa` is 1, `aOut` equals the B-side register.
- R7: `bOe` equals `enAb`, which is active high. `aOe` equals the inverse of `enBaN`, which is active low. Both output enables are active high.
- R8: When a register equals the live value it competes with, its output stays constant, with no change, while the select toggles.
- R9: With `enAb`=1, `enBaN`=0 and both selects at 0, the resolved buses keep their last value after all outside drivers are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ckAb | input | 1 | Capture clock for the A-side register |
| ckBa | input | 1 | Capture clock for the B-side register |
| rstN | input | 1 | Active-low synchronous clear, sampled on each direction clock |
| enAb | input | 1 | Active-high drive enable toward bus B |
| enBaN | input | 1 | Active-low drive enable toward bus A |
| selAb | input | 1 | Source for bus B: 0 live A, 1 stored A |
| selBa | input | 1 | Source for bus A: 0 live B, 1 stored B |
| aIn | input | W | Value sensed on bus A |
| aOut | output | W | Value offered to bus A |
| aOe | output | 1 | Drive enable for bus A |
| bIn | input | W | Value sensed on bus B |
| bOut | output | W | Value offered to bus B |
| bOe | output | 1 | Drive enable for bus B |

## Verification
A capture into a register and a change of select on the same direction can happen close together. The glitch check provokes this. It loads the register with the live value and then toggles the select repeatedly. A monitor counts every change on the output during the toggling, and any count other than zero is judged a failure. A second case checks that a capture taken while that direction is disabled and routing live data lands in the register without disturbing the output. The first later switch to the stored source then has to reveal the new value.

// File: rtl/dualbus_pkg.sv
package dualbus_pkg;
  typedef struct packed {
    logic driveA;     // offer data onto bus A
    logic driveB;     // offer data onto bus B
    logic storedToA;  // bus A source is the B-side register
    logic storedToB;  // bus B source is the A-side register
  } xferStrobe_t;
endpackage

// File: rtl/dualbus_ctrl.sv
module dualbus_ctrl
  import dualbus_pkg::*;
(
  input  logic        enAb,
  input  logic        enBaN,
  input  logic        selAb,
  input  logic        selBa,
  output xferStrobe_t strobe
);
  always_comb begin
    strobe.driveB    = enAb;
    strobe.driveA    = ~enBaN;
    strobe.storedToB = selAb;
    strobe.storedToA = selBa;
  end
endmodule

// File: rtl/dualbus_path.sv
module dualbus_path
  import dualbus_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         ckAb,
  input  logic         ckBa,
  input  logic         rstN,
  input  xferStrobe_t  strobe,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] aOut,
  output logic [W-1:0] bOut
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] regA;
  logic [W-1:0] regB;

  always_ff @(posedge ckAb) begin
    if (!rstN) regA <= ZERO;
    else       regA <= aIn;
  end

  always_ff @(posedge ckBa) begin
    if (!rstN) regB <= ZERO;
    else       regB <= bIn;
  end

  // Per-bit mux with a consensus term: when both sources agree, the bit
  // holds regardless of the select.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bOut[i] = (strobe.storedToB & regA[i]) |
                     (~strobe.storedToB & aIn[i]) |
                     (regA[i] & aIn[i]);
    assign aOut[i] = (strobe.storedToA & regB[i]) |
                     (~strobe.storedToA & bIn[i]) |
                     (regB[i] & bIn[i]);
  end

  // R1
  capA_chk: assert property (@(posedge ckAb) disable iff (!rstN)
    1'b1 |=> regA == $past(aIn));
  // R2
  capB_chk: assert property (@(posedge ckBa) disable iff (!rstN)
    1'b1 |=> regB == $past(bIn));
  // R4
  clrA_chk: assert property (@(posedge ckAb) !rstN |=> regA == ZERO);
  // R4
  clrB_chk: assert property (@(posedge ckBa) !rstN |=> regB == ZERO);

  always_comb begin
    // R5
    if (!strobe.storedToB) liveB_chk: assert (bOut == aIn);
    // R6
    if (strobe.storedToB) storeB_chk: assert (bOut == regA);
    // R8
    if (regA == aIn) agreeB_chk: assert (bOut == aIn);
    // R8
    if (regB == bIn) agreeA_chk: assert (aOut == bIn);
  end
endmodule

// File: rtl/dualbus_xfer.sv
module dualbus_xfer
  import dualbus_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         ckAb,
  input  logic         ckBa,
  input  logic         rstN,
  input  logic         enAb,
  input  logic         enBaN,
  input  logic         selAb,
  input  logic         selBa,
  input  logic [W-1:0] aIn,
  output logic [W-1:0] aOut,
  output logic         aOe,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] bOut,
  output logic         bOe
);
  xferStrobe_t strobe;

  dualbus_ctrl u_ctrl (
    .enAb   (enAb),
    .enBaN  (enBaN),
    .selAb  (selAb),
    .selBa  (selBa),
    .strobe (strobe)
  );

  dualbus_path #(.W(W)) u_path (
    .ckAb   (ckAb),
    .ckBa   (ckBa),
    .rstN   (rstN),
    .strobe (strobe),
    .aIn    (aIn),
    .bIn    (bIn),
    .aOut   (aOut),
    .bOut   (bOut)
  );

  assign aOe = strobe.driveA;
  assign bOe = strobe.driveB;

  always_comb begin
    // R7
    oePol_chk: assert (aOe == ~enBaN && bOe == enAb);
  end
endmodule

// File: tb/sim_dualbus_xfer.sv
`timescale 1ns/1ps
module sim_dualbus_xfer;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic ckAb = 0, ckBa = 0, rstN = 0;
  logic enAb = 0, enBaN = 1, selAb = 0, selBa = 0;
  logic [W-1:0] aOut, bOut;
  logic aOe, bOe;
  logic extAOn = 0, extBOn = 0;
  logic [W-1:0] extA = '0, extB = '0;
  logic [W-1:0] busA, busB;

  // Bus resolution: outside driver wins, then the block; an undriven bus reads 0.
  assign #1 busA = extAOn ? extA : (aOe ? aOut : '0);
  assign #1 busB = extBOn ? extB : (bOe ? bOut : '0);

  dualbus_xfer #(.W(W)) u0 (
    .ckAb(ckAb), .ckBa(ckBa), .rstN(rstN), .enAb(enAb), .enBaN(enBaN),
    .selAb(selAb), .selBa(selBa), .aIn(busA), .aOut(aOut), .aOe(aOe),
    .bIn(busB), .bOut(bOut), .bOe(bOe)
  );

  int checks = 0, errors = 0, cycles = 0;
  int glitchCnt = 0;
  logic watch = 0;
  always @(bOut) if (watch) glitchCnt++;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(); #5; endtask
  task automatic pulseAb(); #2 ckAb = 1; #2 ckAb = 0; #2; endtask
  task automatic pulseBa(); #2 ckBa = 1; #2 ckBa = 0; #2; endtask

  task automatic t_reset();
    extAOn = 1; extA = 8'h77; extBOn = 1; extB = 8'h99;
    rstN = 0; settle(); pulseAb(); pulseBa(); rstN = 1;
    selAb = 1; selBa = 1; settle();
    chk("R4 A-side cleared", bOut, 8'h00);
    chk("R4 B-side cleared", aOut, 8'h00);
  endtask

  task automatic t_live();
    selAb = 0; selBa = 0;
    extA = 8'h3C; extB = 8'hA5; settle();
    chk("R5 live A to B", bOut, 8'h3C);
    chk("R5 live B to A", aOut, 8'hA5);
    extA = 8'hFF; extB = 8'h00; settle();
    chk("R5 live A to B ff", bOut, 8'hFF);
    chk("R5 live B to A 00", aOut, 8'h00);
  endtask

  task automatic t_stored();
    extA = 8'h5E; settle(); pulseAb();
    extB = 8'h81; settle(); pulseBa();
    extA = 8'h01; extB = 8'h02; selAb = 1; selBa = 1; settle();
    chk("R1 R6 stored A", bOut, 8'h5E);
    chk("R2 R6 stored B", aOut, 8'h81);
  endtask

  task automatic t_indep();
    enAb = 0; enBaN = 1; selAb = 0; selBa = 0;
    extA = 8'h12; extB = 8'h34; settle(); pulseAb();
    chk("R3 output live during capture", bOut, 8'h12);
    extA = 8'hEE; selAb = 1; selBa = 1; settle();
    chk("R3 capture while disabled", bOut, 8'h12);
    chk("R3 B-side untouched", aOut, 8'h81);
    extB = 8'h4B; settle(); pulseBa(); settle();
    chk("R3 A-side untouched", bOut, 8'h12);
    chk("R2 B capture", aOut, 8'h4B);
  endtask

  task automatic t_enables();
    enAb = 1; enBaN = 1; settle();
    chk("R7 bOe high", {7'b0, bOe}, 8'h01);
    chk("R7 aOe low", {7'b0, aOe}, 8'h00);
    enAb = 0; enBaN = 0; settle();
    chk("R7 bOe low", {7'b0, bOe}, 8'h00);
    chk("R7 aOe high", {7'b0, aOe}, 8'h01);
    enAb = 0; enBaN = 1; settle();
  endtask

  task automatic t_glitch();
    extA = 8'h66; selAb = 0; settle(); pulseAb(); settle();
    glitchCnt = 0; watch = 1;
    for (int i = 0; i < 6; i++) begin
      selAb = ~selAb; #1;
    end
    settle(); watch = 0;
    chk("R8 no output change on select toggle", glitchCnt[W-1:0], 8'h00);
    chk("R8 value held", bOut, 8'h66);
  endtask

  task automatic t_keeper();
    selAb = 0; selBa = 0; enAb = 1; enBaN = 0;
    extBOn = 0; extAOn = 1; extA = 8'h5A; settle();
    chk("R9 loop carries A to B", busB, 8'h5A);
    extAOn = 0; settle(); settle();
    chk("R9 bus A held", busA, 8'h5A);
    chk("R9 bus B held", busB, 8'h5A);
    extBOn = 1; extB = 8'hC3; settle(); extBOn = 0; settle(); settle();
    chk("R9 bus A held after B release", busA, 8'hC3);
    chk("R9 bus B held after B release", busB, 8'hC3);
  endtask

  initial begin
    t_reset();
    t_live();
    t_stored();
    t_indep();
    t_enables();
    t_glitch();
    t_keeper();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule